// File: doc/BRIEF.md
# Bidirectional Open-Drain Line Arbiter

This block is the digital controller for a two-sided, level-shifting transceiver. The transceiver joins a host-side data line to a card-side data line, for example the card data contact or one of the auxiliary contacts. Both lines are open-drain with a passive pull-up. The block samples the level of each line on a fast clock. When one side pulls its line low, that side becomes the master and the block copies the low to the other side. When the master lets go, the block fires a short active pull-up on the copied side so that the rising edge is fast. It then returns to rest.

For each side the block drives two enables: a pull-down enable and an active pull-up enable. The analog drivers, the level shifting and the current limiting sit outside this block. The edge-to-drive delay, the pull-up pulse length and the depth of the input synchronizer are parameters counted in clock cycles.

Top module: `line_dir_arbiter`

## Requirements
- R1: After reset and while idle, all four enables (hostPullDown, hostPullUp, cardPullDown, cardPullUp) are 0.
- R2: In idle, a side whose synchronized level is low becomes master. Count rising edges from the first edge at which that pin is low. The other side's pull-down turns on right after edge SYNC_STAGES+1+DRIVE_DELAY and stays on while the master is low.
- R3: If both sides are seen low in the same idle cycle, the host side becomes master and only cardPullDown is driven.
- R4: If the master holds its line low for at most DRIVE_DELAY cycles, the slave is never pulled down and no pull-up pulse follows. The block returns to idle right after edge SYNC_STAGES+1+L, where L is the number of edges at which the line was low.
- R5: While a master is established, low pulses on the slave side change none of the enables.
- R6: Let the master be low at L > DRIVE_DELAY edges. The slave pull-down drops and the slave pull-up turns on right after edge SYNC_STAGES+1+L. The pull-up stays on for PULSE_LEN cycles. After that all enables are 0.
- R7: A side never has its pull-down and pull-up enabled together, and the master side is never driven by the block.
- R8: A side that goes low during the pull-up pulse is taken as the new master only once the block is back in idle. Its opposite pull-down follows DRIVE_DELAY cycles after that choice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostLine | input | 1 | Level seen on the host-side line |
| cardLine | input | 1 | Level seen on the card-side line |
| hostPullDown | output | 1 | Enable for the host-side low driver |
| hostPullUp | output | 1 | Enable for the host-side active pull-up |
| cardPullDown | output | 1 | Enable for the card-side low driver |
| cardPullUp | output | 1 | Enable for the card-side active pull-up |

## Verification
The bench builds the block with SYNC_STAGES=2, DRIVE_DELAY=3 and PULSE_LEN=4. With these values a full exchange fits in under twenty cycles, so the bench sweeps master hold lengths from 1 to 12 cycles on both sides. It predicts all four enables on every cycle from the closed-form timing in R2, R4 and R6. The sweep covers the boundary between a glitch that is dropped and a transfer that is driven, which lies at hold lengths 3 and 4. On the same short timeline the bench also places collisions in the same cycle, slave-side pulses during the wait and drive phases, and a new low that arrives in the middle of the pull-up pulse.

// File: rtl/lda_pkg.sv
package lda_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WAIT  = 2'd1,
    PH_DRIVE = 2'd2,
    PH_PULSE = 2'd3
  } phase_e;

  // Control to datapath: which enables to raise and whether the timer restarts
  typedef struct packed {
    logic clrTimer;
    logic driveHost;
    logic driveCard;
    logic pulseHost;
    logic pulseCard;
  } ctlStrobe_t;

  // Datapath to control: synchronized levels and timer flags
  typedef struct packed {
    logic hostLow;
    logic cardLow;
    logic delayDone;
    logic pulseDone;
  } lineStat_t;

endpackage

// File: rtl/lda_datapath.sv
module lda_datapath
  import lda_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DRIVE_DELAY = 3,
  parameter int PULSE_LEN   = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostLine,
  input  logic       cardLine,
  input  ctlStrobe_t strb,
  output lineStat_t  stat,
  output logic       hostPullDown,
  output logic       hostPullUp,
  output logic       cardPullDown,
  output logic       cardPullUp
);

  localparam int MAX_COUNT = (DRIVE_DELAY > PULSE_LEN) ? DRIVE_DELAY : PULSE_LEN;
  localparam int TW        = $clog2(MAX_COUNT + 1);
  localparam logic [TW-1:0] DELAY_LAST = TW'(DRIVE_DELAY - 1);
  localparam logic [TW-1:0] PULSE_LAST = TW'(PULSE_LEN - 1);
  localparam logic [TW-1:0] SAT_VALUE  = TW'(MAX_COUNT);

  logic [SYNC_STAGES-1:0] hostSync;
  logic [SYNC_STAGES-1:0] cardSync;
  logic [TW-1:0]          timer;

  // Input synchronizers; lines rest high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostSync <= '1;
      cardSync <= '1;
    end else begin
      hostSync[0] <= hostLine;
      cardSync[0] <= cardLine;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        hostSync[i] <= hostSync[i-1];
        cardSync[i] <= cardSync[i-1];
      end
    end
  end

  // Shared phase timer, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer <= '0;
    end else if (strb.clrTimer) begin
      timer <= '0;
    end else if (timer != SAT_VALUE) begin
      timer <= timer + 1'b1;
    end
  end

  always_comb begin
    stat.hostLow   = ~hostSync[SYNC_STAGES-1];
    stat.cardLow   = ~cardSync[SYNC_STAGES-1];
    stat.delayDone = (timer == DELAY_LAST);
    stat.pulseDone = (timer == PULSE_LAST);
  end

  assign hostPullDown = strb.driveHost;
  assign hostPullUp   = strb.pulseHost;
  assign cardPullDown = strb.driveCard;
  assign cardPullUp   = strb.pulseCard;

  // R7: one side never pulls both ways
  a_r7_side_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(hostPullDown && hostPullUp) && !(cardPullDown && cardPullUp));

  // R7: only one side is ever driven at a time
  a_r7_one_side: assert property (@(posedge clk) disable iff (!rstN)
    !((hostPullDown || hostPullUp) && (cardPullDown || cardPullUp)));

  // R6: a pull-up pulse always follows a pull-down on the same side
  a_r6_card_pulse_after_drive: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cardPullUp) |-> $past(cardPullDown));

  a_r6_host_pulse_after_drive: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostPullUp) |-> $past(hostPullDown));

endmodule

// File: rtl/lda_ctrl.sv
module lda_ctrl
  import lda_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  lineStat_t  stat,
  output ctlStrobe_t strb
);

  phase_e phase, phaseNext;
  logic   masterIsCard, masterNext;
  logic   masterLow;

  assign masterLow = masterIsCard ? stat.cardLow : stat.hostLow;

  always_comb begin
    phaseNext  = phase;
    masterNext = masterIsCard;
    unique case (phase)
      PH_IDLE: begin
        if (stat.hostLow) begin
          phaseNext  = PH_WAIT;
          masterNext = 1'b0;
        end else if (stat.cardLow) begin
          phaseNext  = PH_WAIT;
          masterNext = 1'b1;
        end
      end
      PH_WAIT: begin
        if (!masterLow)          phaseNext = PH_IDLE;
        else if (stat.delayDone) phaseNext = PH_DRIVE;
      end
      PH_DRIVE: begin
        if (!masterLow) phaseNext = PH_PULSE;
      end
      PH_PULSE: begin
        if (stat.pulseDone) phaseNext = PH_IDLE;
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase        <= PH_IDLE;
      masterIsCard <= 1'b0;
    end else begin
      phase        <= phaseNext;
      masterIsCard <= masterNext;
    end
  end

  always_comb begin
    strb.clrTimer  = (phase == PH_IDLE) || (phase == PH_DRIVE);
    strb.driveHost = (phase == PH_DRIVE) &&  masterIsCard;
    strb.driveCard = (phase == PH_DRIVE) && !masterIsCard;
    strb.pulseHost = (phase == PH_PULSE) &&  masterIsCard;
    strb.pulseCard = (phase == PH_PULSE) && !masterIsCard;
  end

  // R3: simultaneous lows resolve to the host side
  a_r3_host_wins: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE && stat.hostLow && stat.cardLow)
      |=> (phase == PH_WAIT && !masterIsCard));

  // R5: the master choice holds until the block is idle again
  a_r5_master_held: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_IDLE) |=> (phase == PH_IDLE || $stable(masterIsCard)));

  // R4: no drive before the delay timer has run out
  a_r4_no_early_drive: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_WAIT && !stat.delayDone) |=> (phase != PH_DRIVE));

  // R8: the pulse ends only in idle, never straight into a new master
  a_r8_pulse_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_PULSE) |=> (phase == PH_PULSE || phase == PH_IDLE));

endmodule

// File: rtl/line_dir_arbiter.sv
module line_dir_arbiter
  import lda_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DRIVE_DELAY = 3,
  parameter int PULSE_LEN   = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic hostLine,
  input  logic cardLine,
  output logic hostPullDown,
  output logic hostPullUp,
  output logic cardPullDown,
  output logic cardPullUp
);

  ctlStrobe_t strb;
  lineStat_t  stat;

  lda_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .stat (stat),
    .strb (strb)
  );

  lda_datapath #(
    .SYNC_STAGES (SYNC_STAGES),
    .DRIVE_DELAY (DRIVE_DELAY),
    .PULSE_LEN   (PULSE_LEN)
  ) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .hostLine     (hostLine),
    .cardLine     (cardLine),
    .strb         (strb),
    .stat         (stat),
    .hostPullDown (hostPullDown),
    .hostPullUp   (hostPullUp),
    .cardPullDown (cardPullDown),
    .cardPullUp   (cardPullUp)
  );

endmodule

// File: tb/line_dir_arbiter_bench.sv
module line_dir_arbiter_bench;

  localparam int S = 2;
  localparam int D = 3;
  localparam int P = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostExt = 1'b0;
  logic cardExt = 1'b0;
  logic hostPullDown, hostPullUp, cardPullDown, cardPullUp;
  logic hostLine, cardLine;

  int checkCnt = 0;
  int failCnt  = 0;

  always #5 clk = ~clk;

  // Wired open-drain lines
  assign hostLine = !(hostExt || hostPullDown);
  assign cardLine = !(cardExt || cardPullDown);

  line_dir_arbiter #(.SYNC_STAGES(S), .DRIVE_DELAY(D), .PULSE_LEN(P)) u_line_dir_arbiter (
    .clk(clk), .rstN(rstN), .hostLine(hostLine), .cardLine(cardLine),
    .hostPullDown(hostPullDown), .hostPullUp(hostPullUp),
    .cardPullDown(cardPullDown), .cardPullUp(cardPullUp)
  );

  function automatic logic [3:0] outs();
    return {hostPullDown, hostPullUp, cardPullDown, cardPullUp};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [3:0] act, input logic [3:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  // 0 idle, 1 wait, 2 drive, 3 pulse; k = edges since the line went low
  function automatic int phaseAt(int k, int len);
    if (k < S + 1) return 0;
    if (len <= D) return (k < S + 1 + len) ? 1 : 0;
    if (k < S + 1 + D) return 1;
    if (k < S + 1 + len) return 2;
    if (k < S + 1 + len + P) return 3;
    return 0;
  endfunction

  function automatic logic [3:0] expOuts(int ph, bit cardMaster);
    if (ph == 2) return cardMaster ? 4'b1000 : 4'b0010;
    if (ph == 3) return cardMaster ? 4'b0100 : 4'b0001;
    return 4'b0000;
  endfunction

  // mode 0: single side, 1: both low together (R3), 2: slave disturbance (R5)
  task automatic runPattern(input bit cardMaster, input int len, input int mode, input int distK);
    logic [3:0] e;
    int ph;
    string tag;
    if (mode == 1) begin hostExt = 1'b1; cardExt = 1'b1; end
    else if (cardMaster) cardExt = 1'b1;
    else hostExt = 1'b1;
    for (int k = 1; k <= S + len + P + 4; k++) begin
      @(posedge clk);
      @(negedge clk);
      ph = phaseAt(k, len);
      e = expOuts(ph, cardMaster);
      if (mode == 1) tag = "R3";
      else if (mode == 2) tag = "R5";
      else if (len <= D && ph != 0) tag = "R4";
      else if (ph == 0) tag = "R1";
      else if (ph == 1 || ph == 2) tag = "R2";
      else tag = "R6";
      check(outs() == e, tag, outs(), e);
      check(!(hostPullDown && hostPullUp) && !(cardPullDown && cardPullUp), "R7", outs(), e);
      if (mode == 2 && k == distK) begin
        if (cardMaster) hostExt = 1'b1; else cardExt = 1'b1;
      end
      if (mode == 2 && k == distK + 2) begin
        if (cardMaster) hostExt = 1'b0; else cardExt = 1'b0;
      end
      if (k == len) begin hostExt = 1'b0; cardExt = 1'b0; end
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failCnt++;
    checkCnt++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    logic [3:0] e;
    int newStart;
    repeat (3) @(negedge clk);
    check(outs() == 4'b0000, "R1 in reset", outs(), 4'b0000);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(outs() == 4'b0000, "R1 after reset", outs(), 4'b0000);

    // R2 R4 R6 sweep over hold lengths on both sides
    for (int side = 0; side < 2; side++)
      for (int len = 1; len <= 12; len++)
        runPattern(side[0], len, 0, 0);

    // R3: simultaneous lows
    for (int len = 2; len <= 8; len += 3) runPattern(1'b0, len, 1, 0);

    // R5: slave pulses during wait and drive, for either master
    runPattern(1'b0, 10, 2, 4);
    runPattern(1'b0, 10, 2, 7);
    runPattern(1'b1, 10, 2, 4);
    runPattern(1'b1, 10, 2, 7);

    // R8: card goes low in the middle of the host-mastered pulse
    newStart = S + 1 + 6 + P + 1;
    hostExt = 1'b1;
    for (int k = 1; k <= newStart + D + 1; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 6) hostExt = 1'b0;
      if (k == S + 1 + 6 + 1) cardExt = 1'b1;
      if (k >= S + 1 + 6 + 2 && k < newStart + D) begin
        e = (k < S + 1 + 6 + P) ? 4'b0001 : 4'b0000;
        check(outs() == e, "R8 wait for idle", outs(), e);
      end
      if (k == newStart + D) check(outs() == 4'b1000, "R8 new card master", outs(), 4'b1000);
    end
    cardExt = 1'b0;
    repeat (S + P + 4) @(negedge clk);
    check(outs() == 4'b0000, "R1 final idle", outs(), 4'b0000);

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule